// File: doc/BRIEF.md
# Mid-Range Memory Chip-Select Generator

This block turns a 20-bit processor address into four active-low chip selects for a mid-range memory window. Software programs a base register with the window start and an auxiliary register with the total window size. The window is split into four equal sub-windows, and each chip select covers one of them. The address is sampled on a one-cycle bus strobe, and the selects hold that decode until the next strobe.

The auxiliary register also sets the role of two dual-purpose output pins. In chip-select mode the pins pass on an external active-low peripheral decode. In address mode they carry the values of address bits 2 and 1 that were latched on the last strobe. Both pins stay high after reset until a valid auxiliary write arrives. No write to any other peripheral register is needed to enable them.

Register writes are single-cycle strobes with no back-pressure, so no valid/ready handshake is used. `cfg_sel` = 0 selects the base register and `cfg_sel` = 1 selects the auxiliary register. Base register: bits [15:9] hold address bits [19:13] of the window start. Auxiliary register: bit 15 must be written as 1, bits [14:8] hold the one-hot size field, and bit 7 sets the pin mode.

Top module: `mcs_select_top`

## Requirements
- R1: After reset `mcs_n` is 4'b1111 and `dual_pin` is 2'b11.
- R2: All four `mcs_n` stay high after every strobe until the base register has been written (`cfg_wr` with `cfg_sel`=0).
- R3: In the cycle after a strobe, let k be the one set bit of auxiliary bits [14:8] and L = 13+k, so the total size is 8 KB shifted left by k. If `addr[19:L]` equals the base register's address bits [19:L], exactly one select, `mcs_n[addr[L-1:L-2]]`, is low. Otherwise all four selects are high.
- R4: Between strobes, `mcs_n` and the latched address bits do not change, whatever `addr` does.
- R5: If the size field is not one-hot (zero, or more than one bit set), all selects stay high after a strobe.
- R6: An auxiliary write with bit 15 = 0 is ignored. Size, mode and pin activation keep their previous values.
- R7: When auxiliary bit 7 = 1 (address mode), in the cycle after a strobe `dual_pin` = {addr[2], addr[1]} of that strobe, and it holds until the next strobe.
- R8: `dual_pin` stays 2'b11 until the first valid auxiliary write, whatever `pcs_dec_n` does.
- R9: When auxiliary bit 7 = 0 (chip-select mode) and a valid auxiliary write has occurred, `dual_pin` follows `pcs_dec_n` in the same cycle.
- R10: Base register bits below the total-size boundary are ignored, so the window is aligned down to a multiple of the total size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 = base, 1 = auxiliary |
| cfg_wdata | input | 16 | Register write data |
| addr_strobe | input | 1 | Bus-cycle address strobe, one cycle per bus cycle |
| addr | input | 20 | Processor address |
| pcs_dec_n | input | 2 | External active-low peripheral select decode for pins 0 and 1 |
| mcs_n | output | 4 | Active-low mid-range memory selects |
| dual_pin | output | 2 | Dual-purpose pins: peripheral selects, or latched {a2, a1} |

## Verification
The assertions check the following on every cycle:
- At most one memory select is low at any time.
- The selects stay idle until the base register has been written.
- The selects are stable whenever no strobe occurred.
- The dual pins stay idle before a valid auxiliary write.
- In address mode the pins carry the strobed a2 and a1.
- In chip-select mode the pins follow the external decode.

Some behaviours can only be shown by the bench's scenarios, which compare results against an arithmetic window model:
- The choice of which sub-window select fires for each total size.
- Rejection of non-one-hot size codes.
- Alignment of a misaligned base.
- Ignoring of auxiliary writes that lack the top bit.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  typedef enum logic {
    REG_BASE = 1'b0,
    REG_AUX  = 1'b1
  } cfg_sel_e;

  // True when exactly one bit of the vector is set.
  function automatic logic exactly_one(input logic [31:0] v);
    return $countones(v) == 1;
  endfunction
endpackage

// File: rtl/mcs_cfg_regs.sv
module mcs_cfg_regs #(
  parameter int DATA_W   = 16,
  parameter int SIZE_W   = 7,
  parameter int BASE_W   = 7,
  parameter int SIZE_LSB = 8,
  parameter int MODE_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  mcs_pkg::cfg_sel_e cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [SIZE_W-1:0] size_q,
  output logic [BASE_W-1:0] base_q,
  output logic              addr_mode_q,
  output logic              base_ok_q,
  output logic              aux_ok_q
);
  localparam int LOCK_BIT = DATA_W - 1;

  logic base_wr, aux_wr;
  assign base_wr = cfg_wr && (cfg_sel == mcs_pkg::REG_BASE);
  // auxiliary writes without the top bit set are dropped
  assign aux_wr  = cfg_wr && (cfg_sel == mcs_pkg::REG_AUX) && cfg_wdata[LOCK_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q      <= '0;
      base_q      <= '0;
      addr_mode_q <= 1'b0;
      base_ok_q   <= 1'b0;
      aux_ok_q    <= 1'b0;
    end else begin
      if (base_wr) begin
        base_q    <= cfg_wdata[DATA_W-1 -: BASE_W];
        base_ok_q <= 1'b1;
      end
      if (aux_wr) begin
        size_q      <= cfg_wdata[SIZE_LSB +: SIZE_W];
        addr_mode_q <= cfg_wdata[MODE_BIT];
        aux_ok_q    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mcs_window_decode.sv
module mcs_window_decode #(
  parameter int ADDR_W  = 20,
  parameter int SIZE_W  = 7,
  parameter int MIN_LG  = 13,
  parameter int NUM_SEL = 4
) (
  input  logic [ADDR_W-1:0]        addr,
  input  logic [SIZE_W-1:0]        size,
  input  logic [ADDR_W-MIN_LG-1:0] base,
  input  logic                     enable,
  output logic [NUM_SEL-1:0]       sel_n
);
  localparam int IDX_W  = $clog2(NUM_SEL);
  localparam int BASE_W = ADDR_W - MIN_LG;

  logic [SIZE_W-1:0] hit;
  logic [IDX_W-1:0]  idx_arr [SIZE_W];

  // One comparator per legal total size; base bit k lines up with address bit MIN_LG+k.
  for (genvar k = 0; k < SIZE_W; k++) begin : g_size
    localparam int LG = MIN_LG + k;
    assign hit[k]     = size[k] && (addr[ADDR_W-1:LG] == base[BASE_W-1:k]);
    assign idx_arr[k] = addr[LG-1 -: IDX_W];
  end

  logic             any_hit;
  logic [IDX_W-1:0] idx;

  always_comb begin
    any_hit = 1'b0;
    idx     = '0;
    if (enable && mcs_pkg::exactly_one(32'(size))) begin
      for (int k = 0; k < SIZE_W; k++) begin
        if (hit[k]) begin
          any_hit = 1'b1;
          idx     = idx_arr[k];
        end
      end
    end
  end

  always_comb begin
    sel_n = '1;
    if (any_hit) sel_n[idx] = 1'b0;
  end
endmodule

// File: rtl/mcs_strobe_latch.sv
module mcs_strobe_latch #(
  parameter int NUM_SEL = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               addr_strobe,
  input  logic [NUM_SEL-1:0] sel_n_d,
  input  logic [1:0]         abits_d,
  output logic [NUM_SEL-1:0] sel_n_q,
  output logic [1:0]         abits_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_n_q <= '1;
      abits_q <= '0;
    end else if (addr_strobe) begin
      sel_n_q <= sel_n_d;
      abits_q <= abits_d;
    end
  end
endmodule

// File: rtl/mcs_select_top.sv
module mcs_select_top #(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 16,
  parameter int SIZE_W   = 7,
  parameter int MIN_LG   = 13,
  parameter int NUM_SEL  = 4,
  parameter int SIZE_LSB = 8,
  parameter int MODE_BIT = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic               cfg_sel,
  input  logic [DATA_W-1:0]  cfg_wdata,
  input  logic               addr_strobe,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [1:0]         pcs_dec_n,
  output logic [NUM_SEL-1:0] mcs_n,
  output logic [1:0]         dual_pin
);
  localparam int BASE_W = ADDR_W - MIN_LG;

  logic [SIZE_W-1:0]  size_q;
  logic [BASE_W-1:0]  base_q;
  logic               addr_mode_q, base_ok_q, aux_ok_q;
  logic [NUM_SEL-1:0] sel_n_d;
  logic [1:0]         abits_q;

  mcs_cfg_regs #(
    .DATA_W(DATA_W), .SIZE_W(SIZE_W), .BASE_W(BASE_W),
    .SIZE_LSB(SIZE_LSB), .MODE_BIT(MODE_BIT)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr),
    .cfg_sel(mcs_pkg::cfg_sel_e'(cfg_sel)), .cfg_wdata(cfg_wdata),
    .size_q(size_q), .base_q(base_q), .addr_mode_q(addr_mode_q),
    .base_ok_q(base_ok_q), .aux_ok_q(aux_ok_q)
  );

  mcs_window_decode #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .MIN_LG(MIN_LG), .NUM_SEL(NUM_SEL)
  ) dec_i (
    .addr(addr), .size(size_q), .base(base_q), .enable(base_ok_q), .sel_n(sel_n_d)
  );

  mcs_strobe_latch #(.NUM_SEL(NUM_SEL)) lat_i (
    .clk(clk), .rst_n(rst_n), .addr_strobe(addr_strobe),
    .sel_n_d(sel_n_d), .abits_d({addr[2], addr[1]}),
    .sel_n_q(mcs_n), .abits_q(abits_q)
  );

  // dual-purpose pins: idle until a valid auxiliary write, then by mode
  always_comb begin
    if (!aux_ok_q)        dual_pin = 2'b11;
    else if (addr_mode_q) dual_pin = abits_q;
    else                  dual_pin = pcs_dec_n;
  end
endmodule

// File: rtl/mcs_select_chk.sv
module mcs_select_chk #(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 16,
  parameter int NUM_SEL  = 4,
  parameter int MODE_BIT = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_wr,
  input logic               cfg_sel,
  input logic [DATA_W-1:0]  cfg_wdata,
  input logic               addr_strobe,
  input logic [ADDR_W-1:0]  addr,
  input logic [1:0]         pcs_dec_n,
  input logic [NUM_SEL-1:0] mcs_n,
  input logic [1:0]         dual_pin
);
  logic base_seen, aux_seen, mode_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_seen <= 1'b0;
      aux_seen  <= 1'b0;
      mode_seen <= 1'b0;
    end else begin
      if (cfg_wr && !cfg_sel) base_seen <= 1'b1;
      if (cfg_wr && cfg_sel && cfg_wdata[DATA_W-1]) begin
        aux_seen  <= 1'b1;
        mode_seen <= cfg_wdata[MODE_BIT];
      end
    end
  end

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mcs_n)); // R3
  AST_IDLE_BEFORE_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    !base_seen |-> (mcs_n == '1)); // R2
  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_strobe |=> $stable(mcs_n)); // R4
  AST_PINS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !aux_seen |-> (dual_pin == 2'b11)); // R8
  AST_ADDR_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_seen && mode_seen && addr_strobe && !cfg_wr) |=> (dual_pin == $past({addr[2], addr[1]}))); // R7
  AST_CS_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_seen && !mode_seen) |-> (dual_pin == pcs_dec_n)); // R9
endmodule

bind mcs_select_top mcs_select_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SEL(NUM_SEL), .MODE_BIT(MODE_BIT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
  .cfg_wdata(cfg_wdata), .addr_strobe(addr_strobe), .addr(addr),
  .pcs_dec_n(pcs_dec_n), .mcs_n(mcs_n), .dual_pin(dual_pin)
);

// File: tb/mcs_select_top_tb.sv
module mcs_select_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        addr_strobe = 1'b0;
  logic [19:0] addr = '0;
  logic [1:0]  pcs_dec_n = 2'b11;
  logic [3:0]  mcs_n;
  logic [1:0]  dual_pin;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  mcs_select_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .addr_strobe(addr_strobe), .addr(addr),
    .pcs_dec_n(pcs_dec_n), .mcs_n(mcs_n), .dual_pin(dual_pin)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Arithmetic model: window start aligned down to total size, four equal parts.
  function automatic logic [3:0] exp_mcs(input int a, input int size_k, input int base_addr, input bit base_ok);
    int total, start, idx;
    if (!base_ok || size_k < 0) return 4'hF;
    total = 8192 << size_k;
    start = base_addr - (base_addr % total);
    if (a >= start && a < start + total) begin
      idx = (a - start) / (total / 4);
      return ~(4'b0001 << idx);
    end
    return 4'hF;
  endfunction

  function automatic logic [15:0] base_word(input int base_addr);
    return 16'((base_addr >> 13) << 9);
  endfunction

  function automatic logic [15:0] aux_word(input bit lock, input logic [6:0] size, input bit mode);
    return {lock, size, mode, 7'b0};
  endfunction

  task automatic write_reg(input logic sel, input logic [15:0] data);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic strobe(input logic [19:0] a);
    @(negedge clk);
    addr = a; addr_strobe = 1'b1;
    @(negedge clk);
    addr_strobe = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 mcs_n after reset", 32'(mcs_n), 32'hF);
    check("R1 dual_pin after reset", 32'(dual_pin), 32'h3);
  endtask

  task automatic t_pins_idle_and_lock;
    pcs_dec_n = 2'b00; #1;
    check("R8 pins idle before aux write", 32'(dual_pin), 32'h3);
    write_reg(1'b1, aux_word(1'b0, 7'b0001000, 1'b0));
    #1;
    check("R6 aux write without top bit ignored", 32'(dual_pin), 32'h3);
  endtask

  task automatic t_cs_mode_and_no_base;
    write_reg(1'b1, aux_word(1'b1, 7'b0001000, 1'b0));
    #1;
    check("R9 pins follow decode 00", 32'(dual_pin), 32'h0);
    pcs_dec_n = 2'b01; #1;
    check("R9 pins follow decode 01", 32'(dual_pin), 32'h1);
    strobe(20'h40000);
    check("R2 selects idle before base write", 32'(mcs_n), 32'(exp_mcs(32'h40000, 3, 32'h40000, 1'b0)));
  endtask

  task automatic t_window_64k;
    write_reg(1'b0, base_word(32'h40000));
    strobe(20'h40000);
    check("R3 64K first quarter", 32'(mcs_n), 32'(exp_mcs(32'h40000, 3, 32'h40000, 1'b1)));
    strobe(20'h4C123);
    check("R3 64K last quarter", 32'(mcs_n), 32'(exp_mcs(32'h4C123, 3, 32'h40000, 1'b1)));
    @(negedge clk); addr = 20'h40000;
    @(negedge clk); @(negedge clk);
    check("R4 hold without strobe", 32'(mcs_n), 32'(exp_mcs(32'h4C123, 3, 32'h40000, 1'b1)));
    strobe(20'h50000);
    check("R3 above window", 32'(mcs_n), 32'hF);
    strobe(20'h3FFFF);
    check("R3 below window", 32'(mcs_n), 32'hF);
    strobe(20'h46000);
    check("R3 64K second quarter", 32'(mcs_n), 32'(exp_mcs(32'h46000, 3, 32'h40000, 1'b1)));
  endtask

  task automatic t_alignment;
    write_reg(1'b0, base_word(32'h46000));
    strobe(20'h40000);
    check("R10 misaligned base aligned down", 32'(mcs_n), 32'(exp_mcs(32'h40000, 3, 32'h46000, 1'b1)));
    write_reg(1'b0, base_word(32'h40000));
  endtask

  task automatic t_bad_size;
    write_reg(1'b1, aux_word(1'b1, 7'b0000101, 1'b0));
    strobe(20'h40000);
    check("R5 two size bits", 32'(mcs_n), 32'hF);
    write_reg(1'b1, aux_word(1'b1, 7'b0000000, 1'b0));
    strobe(20'h40000);
    check("R5 zero size", 32'(mcs_n), 32'hF);
  endtask

  task automatic t_other_sizes;
    write_reg(1'b1, aux_word(1'b1, 7'b1000000, 1'b0));
    write_reg(1'b0, base_word(32'h80000));
    strobe(20'hC0000);
    check("R3 512K third quarter", 32'(mcs_n), 32'(exp_mcs(32'hC0000, 6, 32'h80000, 1'b1)));
    strobe(20'h12345);
    check("R3 512K outside", 32'(mcs_n), 32'hF);
    write_reg(1'b1, aux_word(1'b0, 7'b0000001, 1'b0));
    strobe(20'hC0000);
    check("R6 ignored size change", 32'(mcs_n), 32'(exp_mcs(32'hC0000, 6, 32'h80000, 1'b1)));
    write_reg(1'b1, aux_word(1'b1, 7'b0000001, 1'b0));
    write_reg(1'b0, base_word(32'h02000));
    strobe(20'h03800);
    check("R3 8K last quarter", 32'(mcs_n), 32'(exp_mcs(32'h03800, 0, 32'h02000, 1'b1)));
  endtask

  task automatic t_addr_mode;
    pcs_dec_n = 2'b00;
    write_reg(1'b1, aux_word(1'b1, 7'b0000001, 1'b1));
    strobe(20'h00004);
    check("R7 latched a2=1 a1=0", 32'(dual_pin), 32'h2);
    @(negedge clk); addr = 20'h00002;
    @(negedge clk);
    check("R4 latched bits held", 32'(dual_pin), 32'h2);
    strobe(20'h00002);
    check("R7 latched a2=0 a1=1", 32'(dual_pin), 32'h1);
    strobe(20'h00006);
    check("R7 latched a2=1 a1=1", 32'(dual_pin), 32'h3);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pins_idle_and_lock();
    t_cs_mode_and_no_base();
    t_window_64k();
    t_alignment();
    t_bad_size();
    t_other_sizes();
    t_addr_mode();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule